// File: doc/BRIEF.md
# Cascadable 4-Bit Register and ALU Slice

This block is one narrow slice of a bit-sliced processor data path. Several identical copies sit side by side, and each copy holds its own share of every architectural register. The default width is 4 bits, and four copies form a 16-bit machine word. Each slice holds its portion of the program counter, four accumulators and a 16-entry last-in-first-out stack, along with the per-slice status flags. The result carry leaves through `cout`, which feeds `cin` of the next more significant slice. The least significant slice takes its carry from the external sequencer.

An external sequencer supplies a control word every cycle. That word gives an ALU function code, the A-operand source, the B-operand source (an accumulator or an immediate nibble), the destination, a write enable, and the stack push and pop strobes. The result is registered on `y_out`. Registered carry, overflow and local-zero flags go to an outside condition multiplexer. That multiplexer takes carry and overflow from the top slice and forms the word zero condition as the AND of every slice's `flag_z`. This gives the skip-if-zero test needed after an immediate add to an accumulator. A separate address output presents the program counter or one of the two index-capable accumulators.

Top module: `rslice_top`

## Requirements
- R1: A synchronous active-high reset clears the program counter, all accumulators, `y_out`, `flag_c`, `flag_v`, `flag_z` and the stack count, so that `stk_empty`=1 and `stk_full`=0.
- R2: Function code 0 (add) computes A+B+cin and code 1 (subtract) computes A+~B+cin. With four slices chained and cin=1 on the lowest slice for subtract, the word result is modulo 2^16. The top slice `flag_c` equals the word carry, and for subtract 1 means no borrow.
- R3: Function codes 2 (AND), 3 (OR), 4 (XOR), 5 (pass A), 6 (pass B) and 7 (complement A) give the bitwise result with `cout`=0 and carry and overflow flags 0.
- R4: At a clock edge with `wr_en`=1, the ALU result is written to the destination: codes 0 to 3 select accumulators and code 4 selects the program counter. With `wr_en`=0 no register changes.
- R5: The program counter advances by exactly one word when it is added to a zero immediate with cin=1 on the lowest slice. The carry ripples across slices (0x00FF to 0x0100, 0xFFFF to 0x0000).
- R6: An accumulator plus a sign-extended 8-bit immediate is written back. The word zero condition (AND of all `flag_z`) is 1 exactly when that result is zero.
- R7: The top slice `flag_v` is 1 after a signed add or subtract overflow, and 0 otherwise.
- R8: The stack returns pushed values in reverse order. A push stores the ALU result. With A source code 5, the operand is the current top (before any pop in that cycle).
- R9: After 16 pushes `stk_full`=1. A further push keeps the stack full and discards the oldest entry.
- R10: A pop from an empty stack reads zero and leaves `stk_empty`=1.
- R11: `addr_sel` 0 or 1 presents the program counter on `addr_out`, 2 presents accumulator 2 and 3 presents accumulator 3.
- R12: A push and a pop in the same cycle on a non-empty stack replace the top entry, and the depth does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_sel | input | 3 | ALU function code |
| a_sel | input | 3 | A source: 0-3 accumulator, 4 program counter, 5 stack top, else zero |
| b_acc | input | 2 | Accumulator used as B when b_imm is 0 |
| b_imm | input | 1 | Selects imm_in as the B operand |
| imm_in | input | 4 | This slice's nibble of the immediate |
| cin | input | 1 | Carry in from the lower slice or the sequencer |
| dst_sel | input | 3 | Destination: 0-3 accumulator, 4 program counter |
| wr_en | input | 1 | Destination write enable |
| push | input | 1 | Push ALU result onto the stack |
| pop | input | 1 | Pop the stack |
| addr_sel | input | 2 | Address output source |
| y_out | output | 4 | Registered ALU result |
| cout | output | 1 | Carry out to the next slice |
| flag_c | output | 1 | Registered carry |
| flag_v | output | 1 | Registered overflow, meaningful on the top slice |
| flag_z | output | 1 | Registered local all-zero result |
| addr_out | output | 4 | Program counter or index accumulator slice |
| stk_full | output | 1 | Stack holds 16 entries |
| stk_empty | output | 1 | Stack holds no entries |

## Verification
The bench chains four slices and targets the carry boundaries: 0x00FF and 0xFFFF program-counter increments, and subtracts that do and do not borrow. A slice that mishandled the carry chain would leave the upper nibbles stale or fail to wrap to zero. A signed overflow that only shows up through the top slice is also exercised, as is an immediate decrement that reaches zero exactly; a wrong zero combine or sign handling would fail to flag the skip. On the stack, the bench pushes 17 entries, drains the stack, pops once more from empty, and does a simultaneous push and pop. A design that blocks pushes when full, returns stale data from empty, or grows on a replace would hand back the wrong sequence.

// File: rtl/rslice_pkg.sv
package rslice_pkg;
  typedef enum logic [2:0] {
    FN_ADD   = 3'd0,
    FN_SUB   = 3'd1,
    FN_AND   = 3'd2,
    FN_OR    = 3'd3,
    FN_XOR   = 3'd4,
    FN_PASSA = 3'd5,
    FN_PASSB = 3'd6,
    FN_NOTA  = 3'd7
  } fn_e;
endpackage

// File: rtl/rslice_alu.sv
module rslice_alu #(
  parameter int W = 4
) (
  input  logic [2:0]   fn,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] res,
  output logic         cout,
  output logic         ovf
);
  import rslice_pkg::*;

  fn_e          fsel;
  logic [W-1:0] bx;
  logic [W:0]   sum;

  assign fsel = fn_e'(fn);
  assign bx   = (fsel == FN_SUB) ? ~b : b;
  assign sum  = {1'b0, a} + {1'b0, bx} + {{W{1'b0}}, cin};

  always_comb begin
    res  = '0;
    cout = 1'b0;
    ovf  = 1'b0;
    case (fsel)
      FN_ADD, FN_SUB: begin
        res  = sum[W-1:0];
        cout = sum[W];
        ovf  = (a[W-1] == bx[W-1]) && (sum[W-1] != a[W-1]);
      end
      FN_AND:   res = a & b;
      FN_OR:    res = a | b;
      FN_XOR:   res = a ^ b;
      FN_PASSA: res = a;
      FN_PASSB: res = b;
      FN_NOTA:  res = ~a;
      default:  res = '0;
    endcase
  end
endmodule

// File: rtl/rslice_regs.sv
module rslice_regs #(
  parameter int W     = 4,
  parameter int NACC  = 4,
  parameter int SW    = 3,
  parameter int IDX_A = 2,
  parameter int IDX_B = 3,
  localparam int AW   = $clog2(NACC)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [SW-1:0] dst_sel,
  input  logic [W-1:0]  wdata,
  input  logic [SW-1:0] a_sel,
  input  logic [AW-1:0] b_sel,
  input  logic [1:0]    addr_sel,
  output logic [W-1:0]  a_val,
  output logic [W-1:0]  b_val,
  output logic [W-1:0]  addr_val
);
  localparam logic [SW-1:0] PC_CODE = SW'(NACC);

  logic [W-1:0] acc_q [NACC];
  logic [W-1:0] pc_q;

  for (genvar g = 0; g < NACC; g++) begin : g_acc
    always_ff @(posedge clk) begin
      if (rst)
        acc_q[g] <= '0;
      else if (wr_en && dst_sel == SW'(g))
        acc_q[g] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      pc_q <= '0;
    else if (wr_en && dst_sel == PC_CODE)
      pc_q <= wdata;
  end

  always_comb begin
    if (a_sel == PC_CODE)
      a_val = pc_q;
    else if (a_sel < PC_CODE)
      a_val = acc_q[a_sel[AW-1:0]];
    else
      a_val = '0;
  end

  assign b_val = acc_q[b_sel];

  always_comb begin
    case (addr_sel)
      2'd2:    addr_val = acc_q[IDX_A];
      2'd3:    addr_val = acc_q[IDX_B];
      default: addr_val = pc_q;
    endcase
  end
endmodule

// File: rtl/rslice_stack.sv
module rslice_stack #(
  parameter int W     = 4,
  parameter int DEPTH = 16,
  localparam int PW   = $clog2(DEPTH)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] din,
  output logic [W-1:0] top,
  output logic         full,
  output logic         empty
);
  localparam logic [PW:0] CAP = (PW+1)'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp_q, wp_nxt, tp;
  logic [PW:0]   cnt_q, cnt_nxt;
  logic          has_data, replace;

  assign tp       = wp_q - 1'b1;
  assign has_data = (cnt_q != '0);
  assign replace  = push && pop && has_data;
  assign top      = has_data ? mem[tp] : '0;

  always_ff @(posedge clk) begin
    if (push)
      mem[replace ? tp : wp_q] <= din;
  end

  always_comb begin
    wp_nxt  = wp_q;
    cnt_nxt = cnt_q;
    if (replace) begin
      wp_nxt  = wp_q;
      cnt_nxt = cnt_q;
    end else if (push) begin
      wp_nxt  = wp_q + 1'b1;
      cnt_nxt = (cnt_q == CAP) ? CAP : cnt_q + 1'b1;
    end else if (pop && has_data) begin
      wp_nxt  = tp;
      cnt_nxt = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp_q  <= '0;
      cnt_q <= '0;
      full  <= 1'b0;
      empty <= 1'b1;
    end else begin
      wp_q  <= wp_nxt;
      cnt_q <= cnt_nxt;
      full  <= (cnt_nxt == CAP);
      empty <= (cnt_nxt == '0);
    end
  end
endmodule

// File: rtl/rslice_top.sv
module rslice_top #(
  parameter int W     = 4,
  parameter int NACC  = 4,
  parameter int DEPTH = 16,
  localparam int SW   = $clog2(NACC + 2),
  localparam int AW   = $clog2(NACC)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [2:0]    op_sel,
  input  logic [SW-1:0] a_sel,
  input  logic [AW-1:0] b_acc,
  input  logic          b_imm,
  input  logic [W-1:0]  imm_in,
  input  logic          cin,
  input  logic [SW-1:0] dst_sel,
  input  logic          wr_en,
  input  logic          push,
  input  logic          pop,
  input  logic [1:0]    addr_sel,
  output logic [W-1:0]  y_out,
  output logic          cout,
  output logic          flag_c,
  output logic          flag_v,
  output logic          flag_z,
  output logic [W-1:0]  addr_out,
  output logic          stk_full,
  output logic          stk_empty
);
  localparam logic [SW-1:0] STK_CODE = SW'(NACC + 1);

  logic [W-1:0] reg_a, reg_b, stk_top, op_a, op_b, res;
  logic         c_o, v_o;

  rslice_regs #(.W(W), .NACC(NACC), .SW(SW), .IDX_A(2), .IDX_B(3)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .dst_sel(dst_sel), .wdata(res),
    .a_sel(a_sel), .b_sel(b_acc), .addr_sel(addr_sel),
    .a_val(reg_a), .b_val(reg_b), .addr_val(addr_out)
  );

  rslice_stack #(.W(W), .DEPTH(DEPTH)) u_stack (
    .clk(clk), .rst(rst), .push(push), .pop(pop), .din(res),
    .top(stk_top), .full(stk_full), .empty(stk_empty)
  );

  assign op_a = (a_sel == STK_CODE) ? stk_top : reg_a;
  assign op_b = b_imm ? imm_in : reg_b;

  rslice_alu #(.W(W)) u_alu (
    .fn(op_sel), .a(op_a), .b(op_b), .cin(cin),
    .res(res), .cout(c_o), .ovf(v_o)
  );

  assign cout = c_o;

  always_ff @(posedge clk) begin
    if (rst) begin
      y_out  <= '0;
      flag_c <= 1'b0;
      flag_v <= 1'b0;
      flag_z <= 1'b0;
    end else begin
      y_out  <= res;
      flag_c <= c_o;
      flag_v <= v_o;
      flag_z <= (res == '0);
    end
  end
endmodule

// File: rtl/rslice_chk.sv
module rslice_chk #(
  parameter int W    = 4,
  parameter int NACC = 4,
  localparam int SW  = $clog2(NACC + 2)
) (
  input logic          clk,
  input logic          rst,
  input logic [2:0]    op_sel,
  input logic [SW-1:0] a_sel,
  input logic [SW-1:0] dst_sel,
  input logic          wr_en,
  input logic          push,
  input logic          pop,
  input logic [1:0]    addr_sel,
  input logic [W-1:0]  addr_out,
  input logic [W-1:0]  y_out,
  input logic          cout,
  input logic          flag_c,
  input logic          flag_v,
  input logic          stk_full,
  input logic          stk_empty
);
  localparam logic [SW-1:0] PC_CODE  = SW'(NACC);
  localparam logic [SW-1:0] STK_CODE = SW'(NACC + 1);

  AST_RESET_STATE: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (y_out == '0 && !flag_c && !flag_v && stk_empty && !stk_full)); // R1

  AST_LOGIC_NO_CARRY: assert property (@(posedge clk) disable iff (rst)
    (op_sel >= 3'd2) |-> !cout); // R3

  AST_PC_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!(wr_en && dst_sel == PC_CODE) && addr_sel == 2'd0)
      |=> (addr_sel != 2'd0 || $stable(addr_out))); // R4

  AST_PUSH_NOT_EMPTY: assert property (@(posedge clk) disable iff (rst)
    push |=> !stk_empty); // R8

  AST_FULL_EMPTY_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(stk_full && stk_empty)); // R9

  AST_FULL_STAYS_FULL: assert property (@(posedge clk) disable iff (rst)
    (stk_full && push && !pop) |=> stk_full); // R9

  AST_EMPTY_POP_ZERO: assert property (@(posedge clk) disable iff (rst)
    (stk_empty && pop && !push && a_sel == STK_CODE && op_sel == 3'd5)
      |=> (y_out == '0 && stk_empty)); // R10
endmodule

bind rslice_top rslice_chk #(.W(W), .NACC(NACC)) u_chk (
  .clk(clk), .rst(rst), .op_sel(op_sel), .a_sel(a_sel), .dst_sel(dst_sel),
  .wr_en(wr_en), .push(push), .pop(pop), .addr_sel(addr_sel),
  .addr_out(addr_out), .y_out(y_out), .cout(cout), .flag_c(flag_c),
  .flag_v(flag_v), .stk_full(stk_full), .stk_empty(stk_empty)
);

// File: tb/rslice_top_tb.sv
`timescale 1ns/1ps
module rslice_top_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  op_sel = '0;
  logic [2:0]  a_sel = '0;
  logic [1:0]  b_acc = '0;
  logic        b_imm = 1'b0;
  logic [15:0] imm = '0;
  logic        cin0 = 1'b0;
  logic [2:0]  dst_sel = 3'd7;
  logic        wr_en = 1'b0;
  logic        push = 1'b0;
  logic        pop = 1'b0;
  logic [1:0]  addr_sel = '0;

  logic [3:0]  y_s [4];
  logic [3:0]  ad_s [4];
  logic [4:0]  carry;
  logic [3:0]  fc, fv, fz, ff, fe;

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;

  always #2 clk = ~clk;

  assign carry[0] = cin0;

  for (genvar g = 0; g < 4; g++) begin : g_sl
    rslice_top u_dut (
      .clk(clk), .rst(rst), .op_sel(op_sel), .a_sel(a_sel), .b_acc(b_acc),
      .b_imm(b_imm), .imm_in(imm[4*g +: 4]), .cin(carry[g]),
      .dst_sel(dst_sel), .wr_en(wr_en), .push(push), .pop(pop),
      .addr_sel(addr_sel), .y_out(y_s[g]), .cout(carry[g+1]),
      .flag_c(fc[g]), .flag_v(fv[g]), .flag_z(fz[g]), .addr_out(ad_s[g]),
      .stk_full(ff[g]), .stk_empty(fe[g])
    );
  end

  wire [15:0] y16  = {y_s[3], y_s[2], y_s[1], y_s[0]};
  wire [15:0] ad16 = {ad_s[3], ad_s[2], ad_s[1], ad_s[0]};
  wire        wc   = fc[3];
  wire        wv   = fv[3];
  wire        wz   = &fz;

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(input logic [2:0] op, input logic [2:0] as, input logic [1:0] ba,
                      input logic bi, input logic [15:0] iv, input logic ci,
                      input logic [2:0] ds, input logic we, input logic ps, input logic pp);
    @(negedge clk);
    op_sel = op; a_sel = as; b_acc = ba; b_imm = bi; imm = iv; cin0 = ci;
    dst_sel = ds; wr_en = we; push = ps; pop = pp;
    @(posedge clk);
    #1;
  endtask

  task automatic ld(input logic [2:0] ds, input logic [15:0] v);
    step(3'd6, 3'd0, 2'd0, 1'b1, v, 1'b0, ds, 1'b1, 1'b0, 1'b0);
  endtask

  task automatic rd(input logic [2:0] as, output logic [15:0] v);
    step(3'd5, as, 2'd0, 1'b0, 16'h0, 1'b0, 3'd7, 1'b0, 1'b0, 1'b0);
    v = y16;
  endtask

  task automatic spush(input logic [15:0] v);
    step(3'd6, 3'd0, 2'd0, 1'b1, v, 1'b0, 3'd7, 1'b0, 1'b1, 1'b0);
  endtask

  task automatic spop(output logic [15:0] v);
    step(3'd5, 3'd5, 2'd0, 1'b0, 16'h0, 1'b0, 3'd7, 1'b0, 1'b0, 1'b1);
    v = y16;
  endtask

  task automatic t_r1_reset();
    logic [15:0] v;
    chk("R1 y", y16, 16'h0);
    chk("R1 flags", {13'h0, wc, wv, fz[0]}, 16'h0);
    chk("R1 stack", {14'h0, ff[0], fe[0]}, 16'h1);
    for (int i = 0; i < 5; i++) begin
      rd(3'(i), v);
      chk("R1 reg", v, 16'h0);
    end
  endtask

  task automatic t_r2_arith();
    logic [15:0] v;
    ld(3'd0, 16'h1234); ld(3'd1, 16'h0FFF);
    step(3'd0, 3'd0, 2'd1, 1'b0, 16'h0, 1'b0, 3'd2, 1'b1, 1'b0, 1'b0);
    chk("R2 add", y16, 16'h2233); chk("R2 add carry", {15'h0, wc}, 16'h0);
    rd(3'd2, v); chk("R2 add dest", v, 16'h2233);
    step(3'd1, 3'd0, 2'd1, 1'b0, 16'h0, 1'b1, 3'd7, 1'b0, 1'b0, 1'b0);
    chk("R2 sub", y16, 16'h0235); chk("R2 sub no borrow", {15'h0, wc}, 16'h1);
    ld(3'd0, 16'hFFFF);
    step(3'd0, 3'd0, 2'd0, 1'b1, 16'h0001, 1'b0, 3'd7, 1'b0, 1'b0, 1'b0);
    chk("R2 wrap", y16, 16'h0000); chk("R2 wrap carry", {15'h0, wc}, 16'h1);
    ld(3'd0, 16'h0001);
    step(3'd1, 3'd0, 2'd0, 1'b1, 16'h0002, 1'b1, 3'd7, 1'b0, 1'b0, 1'b0);
    chk("R2 borrow", y16, 16'hFFFF); chk("R2 borrow carry", {15'h0, wc}, 16'h0);
  endtask

  task automatic t_r3_logic();
    ld(3'd0, 16'hF0F0); ld(3'd1, 16'h3C3C);
    step(3'd2, 3'd0, 2'd1, 1'b0, 16'h0, 1'b1, 3'd7, 1'b0, 1'b0, 1'b0);
    chk("R3 and", y16, 16'h3030); chk("R3 carry", {14'h0, wc, wv}, 16'h0);
    step(3'd3, 3'd0, 2'd1, 1'b0, 16'h0, 1'b0, 3'd7, 1'b0, 1'b0, 1'b0);
    chk("R3 or", y16, 16'hFCFC);
    step(3'd4, 3'd0, 2'd1, 1'b0, 16'h0, 1'b0, 3'd7, 1'b0, 1'b0, 1'b0);
    chk("R3 xor", y16, 16'hCCCC);
    step(3'd7, 3'd0, 2'd1, 1'b0, 16'h0, 1'b0, 3'd7, 1'b0, 1'b0, 1'b0);
    chk("R3 not", y16, 16'h0F0F);
    step(3'd6, 3'd0, 2'd1, 1'b0, 16'h0, 1'b0, 3'd7, 1'b0, 1'b0, 1'b0);
    chk("R3 passb", y16, 16'h3C3C);
  endtask

  task automatic t_r4_write_enable();
    logic [15:0] v;
    ld(3'd3, 16'h5A5A);
    step(3'd6, 3'd0, 2'd0, 1'b1, 16'h1111, 1'b0, 3'd3, 1'b0, 1'b0, 1'b0);
    rd(3'd3, v); chk("R4 no write", v, 16'h5A5A);
    ld(3'd3, 16'h2222);
    rd(3'd3, v); chk("R4 write", v, 16'h2222);
  endtask

  task automatic t_r5_pc_inc();
    logic [15:0] v;
    ld(3'd4, 16'h00FF);
    addr_sel = 2'd0;
    step(3'd0, 3'd4, 2'd0, 1'b1, 16'h0, 1'b1, 3'd4, 1'b1, 1'b0, 1'b0);
    chk("R5 pc addr", ad16, 16'h0100);
    rd(3'd4, v); chk("R5 pc read", v, 16'h0100);
    ld(3'd4, 16'hFFFF);
    step(3'd0, 3'd4, 2'd0, 1'b1, 16'h0, 1'b1, 3'd4, 1'b1, 1'b0, 1'b0);
    chk("R5 pc wrap", ad16, 16'h0000);
  endtask

  task automatic t_r6_isz();
    logic [15:0] v;
    ld(3'd1, 16'h0002);
    step(3'd0, 3'd1, 2'd0, 1'b1, 16'hFFFF, 1'b0, 3'd1, 1'b1, 1'b0, 1'b0);
    chk("R6 dec", y16, 16'h0001); chk("R6 nonzero", {15'h0, wz}, 16'h0);
    step(3'd0, 3'd1, 2'd0, 1'b1, 16'hFFFF, 1'b0, 3'd1, 1'b1, 1'b0, 1'b0);
    chk("R6 zero flag", {15'h0, wz}, 16'h1);
    rd(3'd1, v); chk("R6 acc", v, 16'h0000);
  endtask

  task automatic t_r7_overflow();
    ld(3'd0, 16'h7FFF);
    step(3'd0, 3'd0, 2'd0, 1'b1, 16'h0001, 1'b0, 3'd7, 1'b0, 1'b0, 1'b0);
    chk("R7 add ovf", {y16[15:1], wv}, {15'h4000, 1'b1});
    ld(3'd0, 16'h1000);
    step(3'd0, 3'd0, 2'd0, 1'b1, 16'h1000, 1'b0, 3'd7, 1'b0, 1'b0, 1'b0);
    chk("R7 no ovf", {15'h0, wv}, 16'h0);
    ld(3'd0, 16'h8000);
    step(3'd1, 3'd0, 2'd0, 1'b1, 16'h0001, 1'b1, 3'd7, 1'b0, 1'b0, 1'b0);
    chk("R7 sub ovf", y16, 16'h7FFF); chk("R7 sub flag", {15'h0, wv}, 16'h1);
  endtask

  task automatic t_r11_index();
    ld(3'd2, 16'hABCD); ld(3'd3, 16'h1357);
    addr_sel = 2'd2; #1; chk("R11 idx2", ad16, 16'hABCD);
    addr_sel = 2'd3; #1; chk("R11 idx3", ad16, 16'h1357);
    addr_sel = 2'd0;
  endtask

  task automatic t_r8_lifo();
    logic [15:0] v;
    spush(16'h0005); spush(16'h0006); spush(16'h0007);
    chk("R8 not empty", {15'h0, fe[0]}, 16'h0);
    spop(v); chk("R8 pop1", v, 16'h0007);
    spop(v); chk("R8 pop2", v, 16'h0006);
    spop(v); chk("R8 pop3", v, 16'h0005);
    chk("R8 empty", {15'h0, fe[0]}, 16'h1);
  endtask

  task automatic t_r9_overwrite();
    logic [15:0] v;
    for (int i = 1; i <= 16; i++) spush(16'(i));
    chk("R9 full", {15'h0, ff[0]}, 16'h1);
    spush(16'd17);
    chk("R9 still full", {15'h0, ff[0]}, 16'h1);
    for (int i = 17; i >= 2; i--) begin
      spop(v); chk("R9 order", v, 16'(i));
    end
    chk("R9 drained", {14'h0, ff[0], fe[0]}, 16'h1);
  endtask

  task automatic t_r10_underflow();
    logic [15:0] v;
    spop(v); chk("R10 empty pop", v, 16'h0);
    chk("R10 flags", {14'h0, ff[0], fe[0]}, 16'h1);
  endtask

  task automatic t_r12_replace();
    logic [15:0] v;
    spush(16'h0009);
    step(3'd6, 3'd0, 2'd0, 1'b1, 16'h0004, 1'b0, 3'd7, 1'b0, 1'b1, 1'b1);
    spop(v); chk("R12 replaced", v, 16'h0004);
    chk("R12 depth", {15'h0, fe[0]}, 16'h1);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    #1;
    t_r1_reset();
    t_r2_arith();
    t_r3_logic();
    t_r4_write_enable();
    t_r5_pc_inc();
    t_r6_isz();
    t_r7_overflow();
    t_r11_index();
    t_r8_lifo();
    t_r9_overwrite();
    t_r10_underflow();
    t_r12_replace();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule